// File: doc/BRIEF.md
# Macroblock Pixel Output Sequencer

This block streams decoded macroblocks from a local word buffer to a display processor. Each macroblock leaves as 96 words of 32 bits. Each word packs four horizontally adjacent 8-bit pixels. The first 64 words carry luma, held in the buffer as 16 rows of four words. The last 32 words carry chroma. A picture holds `MB_ROWS` rows of `MB_COLS` macroblocks. The block frames the traffic with three strobes: a picture window, a slice (macroblock row) window and a macroblock window. It also drives the picture structure code and the active-low first-field flag.

For a frame picture whose macroblock uses field DCT, the luma rows are sent top-field first. All even rows go out before any odd row. The chroma order never changes. A wait input from the display side holds back the next macroblock. A second buffer port lets the upstream logic (here, the bench) load the words.

Top module: `mb_out_seq`

## Requirements
- R1: After reset, pic_win_o, slice_win_o, mb_win_o and mb_fld_o are 0, pic_struct_o is 0 and first_fld_n_o is 1. pix_o is 0 at every clock where mb_win_o is low.
- R2: mb_win_o is high for exactly 96 consecutive clocks per macroblock and carries one buffer word per clock. It stays low for at least 2 clocks between macroblocks.
- R3: With field ordering off, output word k of a macroblock is buffer word k, for k = 0..95. Luma row r sits at words 4r..4r+3, and chroma sits at words 64..95.
- R4: With field_dct_i = 1 in a frame picture (structure code 3), luma output row r (words 4r..4r+3) comes from buffer row 2r for r < 8 and from row 2(r-8)+1 for r >= 8. Words 64..95 keep their order, and mb_fld_o is 1 during the window.
- R5: In a field picture (structure code 1 = top field, 2 = bottom field), field_dct_i has no effect. Words leave in R3 order and mb_fld_o is 0.
- R6: field_dct_i is sampled once, when a macroblock starts. Changes during the window alter neither mb_fld_o nor the word order.
- R7: The picture structure code (1 top, 2 bottom, 3 frame) and first_fld_n_o (0 when first_top_i was 1) change exactly 2 clocks before pic_win_o rises. They hold while pic_win_o is high, then return to 0 and 1 when it falls. A request with code 0 is not accepted.
- R8: pic_win_o stays low for more than 128 clocks before each rise, including the first after reset. A request that arrives sooner is deferred, not lost.
- R9: slice_win_o rises together with the first macroblock window of each row. It stays high through that row, falls together with the row's last window, and stays low for at least 2 clocks between rows.
- R10: No macroblock window starts while wait_i is high. A macroblock already under way still sends all 96 words, so output stops within one macroblock of wait_i rising.
- R11: Every macroblock window lies inside the picture window, and each picture carries exactly MB_COLS*MB_ROWS windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_we_i | input | 1 | Buffer write enable |
| buf_waddr_i | input | 7 | Buffer write word address |
| buf_wdata_i | input | 32 | Buffer write word |
| pic_req_i | input | 1 | Picture request level, held until accepted |
| pic_struct_i | input | 2 | Structure code of the requested picture |
| first_top_i | input | 1 | First field of the picture is the top field |
| field_dct_i | input | 1 | Next macroblock uses field DCT |
| wait_i | input | 1 | Display side asks for a pause |
| pic_win_o | output | 1 | Picture window |
| pic_struct_o | output | 2 | Structure code of the picture on the bus |
| first_fld_n_o | output | 1 | First-field parity, active low |
| slice_win_o | output | 1 | Macroblock row window |
| mb_win_o | output | 1 | Macroblock window |
| mb_fld_o | output | 1 | Current macroblock is sent in field order |
| pix_o | output | 32 | Four packed pixels |

## Verification
The bound checker watches the timing rules on every clock:
- the exact 96-clock macroblock width and the minimum gaps;
- the 2-clock lead and the hold of the picture structure code;
- the more-than-128-clock picture gap;
- slice windows enclosing macroblock windows;
- the mode flag being used only in frame pictures;
- that no window starts after a wait.

Only the bench scenarios can show that the data words match the frame-order and field-order address maps. The same holds for the order being frozen when field_dct_i changes mid-macroblock, for the macroblock and row counts per picture, and for a request made too early being deferred.

// File: rtl/mb_out_pkg.sv
package mb_out_pkg;
  localparam int unsigned PIX_W         = 8;
  localparam int unsigned PIX_PER_WORD  = 4;
  localparam int unsigned WORD_W        = PIX_W * PIX_PER_WORD;
  localparam int unsigned LUMA_ROWS     = 16;
  localparam int unsigned WORDS_PER_ROW = LUMA_ROWS / PIX_PER_WORD;
  localparam int unsigned LUMA_WORDS    = LUMA_ROWS * WORDS_PER_ROW;
  localparam int unsigned CHROMA_WORDS  = LUMA_WORDS / 2;
  localparam int unsigned MB_WORDS      = LUMA_WORDS + CHROMA_WORDS;
  localparam int unsigned ADDR_W        = $clog2(MB_WORDS);
  localparam int unsigned ROW_AW        = $clog2(LUMA_ROWS);
  localparam int unsigned COL_AW        = $clog2(WORDS_PER_ROW);

  typedef logic [1:0] pic_struct_t;
  localparam pic_struct_t PS_NONE  = 2'd0;
  localparam pic_struct_t PS_TOP   = 2'd1;
  localparam pic_struct_t PS_BOT   = 2'd2;
  localparam pic_struct_t PS_FRAME = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP, ST_SEND, ST_END
  } seq_state_e;
endpackage

// File: rtl/mb_buf.sv
module mb_buf #(
  parameter int unsigned DEPTH = 96,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // zero outside the read window keeps the bus quiet between macroblocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[raddr_i];
    else              rdata_o <= '0;
  end
endmodule

// File: rtl/mb_addr_map.sv
module mb_addr_map import mb_out_pkg::*; (
  input  logic [ADDR_W-1:0] word_i,
  input  logic              field_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAD_W = ADDR_W - ROW_AW - COL_AW;

  logic [ROW_AW-1:0] row, src_row;
  logic [COL_AW-1:0] col;
  logic              is_luma;

  assign col     = word_i[COL_AW-1:0];
  assign row     = word_i[COL_AW +: ROW_AW];
  assign is_luma = word_i < ADDR_W'(LUMA_WORDS);
  // row r -> 2r for the upper half, 2(r-half)+1 for the lower half
  assign src_row = {row[ROW_AW-2:0], row[ROW_AW-1]};

  always_comb begin
    addr_o = word_i;
    if (field_i && is_luma) addr_o = {{PAD_W{1'b0}}, src_row, col};
  end
endmodule

// File: rtl/mb_seq_ctrl.sv
module mb_seq_ctrl import mb_out_pkg::*; #(
  parameter int unsigned MB_COLS = 3,
  parameter int unsigned MB_ROWS = 2,
  parameter int unsigned PIC_GAP = 129,
  parameter int unsigned MB_GAP  = 2,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pic_req_i,
  input  pic_struct_t       pic_struct_i,
  input  logic              first_top_i,
  input  logic              field_dct_i,
  input  logic              wait_i,
  output logic              send_o,
  output logic [ADDR_W-1:0] word_o,
  output logic              field_o,
  output logic              slice_o,
  output logic              pdwin_o,
  output pic_struct_t       pstr_o,
  output logic              ffpn_o
);
  localparam int unsigned COL_W   = (MB_COLS > 1) ? $clog2(MB_COLS) : 1;
  localparam int unsigned ROW_W   = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1;
  localparam int unsigned GAP_W   = $clog2(PIC_GAP + 1);
  localparam int unsigned CNT_MAX = (PRE_CYC > MB_GAP) ? PRE_CYC : MB_GAP;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state_q;
  logic [GAP_W-1:0]  gap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] word_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  row_q;
  logic              field_q, slice_q, pdwin_q, ffpn_q;
  pic_struct_t       pstr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      col_q   <= '0;
      row_q   <= '0;
      field_q <= 1'b0;
      slice_q <= 1'b0;
      pdwin_q <= 1'b0;
      pstr_q  <= PS_NONE;
      ffpn_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (gap_q < GAP_W'(PIC_GAP)) begin
            gap_q <= gap_q + 1'b1;
          end else if (pic_req_i && pic_struct_i != PS_NONE) begin
            pstr_q  <= pic_struct_i;
            ffpn_q  <= ~first_top_i;
            cnt_q   <= '0;
            state_q <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (cnt_q == CNT_W'(PRE_CYC - 1)) begin
            pdwin_q <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_q >= CNT_W'(MB_GAP - 1) && !wait_i) begin
            word_q  <= '0;
            field_q <= field_dct_i && (pstr_q == PS_FRAME);
            if (col_q == '0) slice_q <= 1'b1;
            state_q <= ST_SEND;
          end else if (cnt_q < CNT_W'(MB_GAP - 1)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SEND: begin
          word_q <= word_q + 1'b1;
          if (word_q == ADDR_W'(MB_WORDS - 1)) begin
            cnt_q <= '0;
            if (col_q == COL_W'(MB_COLS - 1)) begin
              col_q   <= '0;
              slice_q <= 1'b0;
              if (row_q == ROW_W'(MB_ROWS - 1)) begin
                row_q   <= '0;
                state_q <= ST_END;
              end else begin
                row_q   <= row_q + 1'b1;
                state_q <= ST_GAP;
              end
            end else begin
              col_q   <= col_q + 1'b1;
              state_q <= ST_GAP;
            end
          end
        end
        ST_END: begin
          pdwin_q <= 1'b0;
          pstr_q  <= PS_NONE;
          ffpn_q  <= 1'b1;
          gap_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign send_o  = (state_q == ST_SEND);
  assign word_o  = word_q;
  assign field_o = field_q;
  assign slice_o = slice_q;
  assign pdwin_o = pdwin_q;
  assign pstr_o  = pstr_q;
  assign ffpn_o  = ffpn_q;
endmodule

// File: rtl/mb_out_seq.sv
module mb_out_seq import mb_out_pkg::*; #(
  parameter int unsigned MB_COLS = 3,
  parameter int unsigned MB_ROWS = 2,
  parameter int unsigned PIC_GAP = 129,
  parameter int unsigned MB_GAP  = 2,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [ADDR_W-1:0] buf_waddr_i,
  input  logic [WORD_W-1:0] buf_wdata_i,
  input  logic              pic_req_i,
  input  logic [1:0]        pic_struct_i,
  input  logic              first_top_i,
  input  logic              field_dct_i,
  input  logic              wait_i,
  output logic              pic_win_o,
  output logic [1:0]        pic_struct_o,
  output logic              first_fld_n_o,
  output logic              slice_win_o,
  output logic              mb_win_o,
  output logic              mb_fld_o,
  output logic [WORD_W-1:0] pix_o
);
  logic              send, field, slice;
  logic [ADDR_W-1:0] word, raddr;

  mb_seq_ctrl #(
    .MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .PIC_GAP(PIC_GAP),
    .MB_GAP(MB_GAP), .PRE_CYC(PRE_CYC)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pic_req_i   (pic_req_i),
    .pic_struct_i(pic_struct_i),
    .first_top_i (first_top_i),
    .field_dct_i (field_dct_i),
    .wait_i      (wait_i),
    .send_o      (send),
    .word_o      (word),
    .field_o     (field),
    .slice_o     (slice),
    .pdwin_o     (pic_win_o),
    .pstr_o      (pic_struct_o),
    .ffpn_o      (first_fld_n_o)
  );

  mb_addr_map i_map (
    .word_i (word),
    .field_i(field),
    .addr_o (raddr)
  );

  mb_buf #(.DEPTH(MB_WORDS), .DW(WORD_W), .AW(ADDR_W)) i_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (buf_we_i),
    .waddr_i(buf_waddr_i),
    .wdata_i(buf_wdata_i),
    .rd_en_i(send),
    .raddr_i(raddr),
    .rdata_o(pix_o)
  );

  // strobes take the buffer's read latency so they line up with pix_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_win_o    <= 1'b0;
      slice_win_o <= 1'b0;
      mb_fld_o    <= 1'b0;
    end else begin
      mb_win_o    <= send;
      slice_win_o <= slice;
      mb_fld_o    <= field;
    end
  end
endmodule

// File: rtl/mb_out_seq_chk.sv
module mb_out_seq_chk import mb_out_pkg::*; #(
  parameter int unsigned MB_GAP = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wait_i,
  input logic              pic_win_o,
  input logic [1:0]        pic_struct_o,
  input logic              first_fld_n_o,
  input logic              slice_win_o,
  input logic              mb_win_o,
  input logic              mb_fld_o,
  input logic [WORD_W-1:0] pix_o
);
  localparam int unsigned PIC_LOW_MIN = 128;

  logic [7:0] mb_hi, mb_lo, sl_lo;
  logic [8:0] pic_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_hi <= '0; mb_lo <= '0; sl_lo <= '0; pic_lo <= '0;
    end else begin
      mb_hi  <= mb_win_o ? ((mb_hi == 8'hFF) ? mb_hi : mb_hi + 1'b1) : '0;
      mb_lo  <= !mb_win_o ? ((mb_lo == 8'hFF) ? mb_lo : mb_lo + 1'b1) : '0;
      sl_lo  <= !slice_win_o ? ((sl_lo == 8'hFF) ? sl_lo : sl_lo + 1'b1) : '0;
      pic_lo <= !pic_win_o ? ((pic_lo == 9'h1FF) ? pic_lo : pic_lo + 1'b1) : '0;
    end
  end

  a_r1_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mb_win_o |-> pix_o == '0);
  a_r2_mb_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mb_win_o) |-> mb_hi == 8'(MB_WORDS));
  a_r2_mb_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_win_o |-> mb_hi < 8'(MB_WORDS));
  a_r2_mb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mb_win_o) |-> mb_lo >= 8'(MB_GAP));
  a_r5_fld_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_win_o && mb_fld_o) |-> pic_struct_o == PS_FRAME);
  a_r6_fld_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_win_o && $past(mb_win_o)) |-> $stable(mb_fld_o));
  a_r7_struct_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pic_win_o) |-> (pic_struct_o != PS_NONE
      && $past(pic_struct_o) == pic_struct_o && $past(pic_struct_o, 2) == pic_struct_o
      && $past(pic_struct_o, 3) == PS_NONE && $past(first_fld_n_o, 2) == first_fld_n_o));
  a_r7_struct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pic_win_o && $past(pic_win_o)) |-> ($stable(pic_struct_o) && $stable(first_fld_n_o)));
  a_r8_pic_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pic_win_o) |-> pic_lo > 9'(PIC_LOW_MIN));
  a_r9_slice_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_win_o |-> slice_win_o);
  a_r9_slice_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slice_win_o) |-> (sl_lo >= 8'd2 && $rose(mb_win_o)));
  a_r10_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mb_win_o) |-> !$past(wait_i, 2));
  a_r11_mb_in_pic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_win_o |-> pic_win_o);
endmodule

bind mb_out_seq mb_out_seq_chk #(.MB_GAP(MB_GAP)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wait_i       (wait_i),
  .pic_win_o    (pic_win_o),
  .pic_struct_o (pic_struct_o),
  .first_fld_n_o(first_fld_n_o),
  .slice_win_o  (slice_win_o),
  .mb_win_o     (mb_win_o),
  .mb_fld_o     (mb_fld_o),
  .pix_o        (pix_o)
);

// File: tb/test_mb_out_seq.sv
module test_mb_out_seq;
  localparam int MB_COLS = 3;
  localparam int MB_ROWS = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        buf_we_i = 1'b0;
  logic [6:0]  buf_waddr_i = '0;
  logic [31:0] buf_wdata_i = '0;
  logic        pic_req_i = 1'b0, first_top_i = 1'b0, field_dct_i = 1'b0, wait_i = 1'b0;
  logic [1:0]  pic_struct_i = '0;
  logic        pic_win_o, first_fld_n_o, slice_win_o, mb_win_o, mb_fld_o;
  logic [1:0]  pic_struct_o;
  logic [31:0] pix_o;

  int errs = 0, checks = 0;
  logic [7:0] seed_g = 8'h00;

  always #5 clk_i = ~clk_i;

  mb_out_seq #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS)) i_mb_out_seq (.*);

  function automatic logic [31:0] pat(input int a);
    return {seed_g ^ 8'(a), 8'(a), ~8'(a), 8'(a * 5)};
  endfunction

  function automatic int exp_addr(input int w, input bit fld);
    int r;
    if (w >= 64 || !fld) return w;
    r = w / 4;
    return ((r < 8) ? 2 * r : 2 * (r - 8) + 1) * 4 + w % 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_buf(input logic [7:0] seed);
    seed_g = seed;
    for (int a = 0; a < 96; a++) begin
      @(negedge clk_i);
      buf_we_i = 1'b1; buf_waddr_i = 7'(a); buf_wdata_i = pat(a);
    end
    @(negedge clk_i);
    buf_we_i = 1'b0;
  endtask

  // runs one picture; wt pauses after the first macroblock, tg toggles the mode flag mid-window
  task automatic run_pic(input logic [1:0] ps, input bit ff, input bit fd,
                         input bit wt, input bit tg, output int pre_lo);
    int n_mb, w, bad_d, bad_w, bad_f, bad_hold, bad_sc, bad_sr, bad_z, bad_pic;
    int lead, lo, mb_lo, min_mb_lo, sl_lo, min_sl_lo, n_sl, wait_left, wait_viol;
    bit seen, prev_mb, prev_sl, prev_pd, done, fexp;
    string dreq;
    n_mb = 0; w = 0; bad_d = 0; bad_w = 0; bad_f = 0; bad_hold = 0; bad_sc = 0;
    bad_sr = 0; bad_z = 0; bad_pic = 0; lead = 0; lo = 0; mb_lo = 0; min_mb_lo = 999;
    sl_lo = 0; min_sl_lo = 999; n_sl = 0; wait_left = 0; wait_viol = 0;
    seen = 0; prev_mb = 0; prev_sl = 0; prev_pd = 0; done = 0;
    fexp = fd && (ps == 2'd3);
    dreq = fexp ? "R4" : ((fd && ps != 2'd3) ? "R5" : "R3");
    pic_struct_i = ps; first_top_i = ff; field_dct_i = fd; pic_req_i = 1'b1;
    while (!done) begin
      @(negedge clk_i);
      if (!seen && !pic_win_o) begin
        lo++;
        if (pic_struct_o != 2'd0) begin lead++; pic_req_i = 1'b0; end
      end
      if (pic_win_o && !prev_pd) begin
        seen = 1;
        chk(lead == 2, "R7", "structure lead clocks", lead, 2);
        chk(pic_struct_o == ps, "R7", "structure code", pic_struct_o, ps);
        chk(first_fld_n_o == !ff, "R7", "first field flag", first_fld_n_o, !ff);
      end
      if (pic_win_o && (pic_struct_o != ps || first_fld_n_o != !ff)) bad_hold++;
      if (mb_win_o) begin
        if (!pic_win_o) bad_pic++;
        if (pix_o !== pat(exp_addr(w, fexp))) bad_d++;
        if (mb_fld_o !== fexp) bad_f++;
        if (!slice_win_o) bad_sc++;
        if (!prev_mb && n_mb > 0 && mb_lo < min_mb_lo) min_mb_lo = mb_lo;
        w++; mb_lo = 0;
        if (tg && w == 10) field_dct_i = !fd;
      end else begin
        if (prev_mb) begin
          if (w != 96) bad_w++;
          n_mb++; w = 0; field_dct_i = fd;
          if (wt && n_mb == 1) begin wait_i = 1'b1; wait_left = 150; end
        end
        if (pix_o != 32'd0) bad_z++;
        mb_lo++;
      end
      if (wait_left > 0) begin
        if (mb_win_o) wait_viol++;
        wait_left--;
        if (wait_left == 0) wait_i = 1'b0;
      end
      if (slice_win_o && !prev_sl) begin
        n_sl++;
        if (n_sl > 1 && sl_lo < min_sl_lo) min_sl_lo = sl_lo;
        if (!(mb_win_o && !prev_mb)) bad_sr++;
      end
      if (!slice_win_o) sl_lo++; else sl_lo = 0;
      if (!pic_win_o && prev_pd) done = 1;
      prev_mb = mb_win_o; prev_sl = slice_win_o; prev_pd = pic_win_o;
    end
    pre_lo = lo;
    chk(n_mb == MB_COLS * MB_ROWS, "R11", "macroblocks per picture", n_mb, MB_COLS * MB_ROWS);
    chk(bad_pic == 0, "R11", "windows outside picture", bad_pic, 0);
    chk(bad_w == 0, "R2", "windows not 96 wide", bad_w, 0);
    chk(min_mb_lo >= 2, "R2", "min macroblock gap", min_mb_lo, 2);
    chk(bad_d == 0, dreq, "word order mismatches", bad_d, 0);
    chk(bad_f == 0, tg ? "R6" : dreq, "field flag mismatches", bad_f, 0);
    chk(bad_hold == 0, "R7", "structure changes in window", bad_hold, 0);
    chk(pic_struct_o == 2'd0 && first_fld_n_o == 1'b1, "R7", "structure after fall",
        {pic_struct_o, first_fld_n_o}, 3'b001);
    chk(n_sl == MB_ROWS, "R9", "slice count", n_sl, MB_ROWS);
    chk(min_sl_lo >= 2, "R9", "min slice gap", min_sl_lo, 2);
    chk(bad_sc == 0 && bad_sr == 0, "R9", "slice framing errors", bad_sc + bad_sr, 0);
    chk(bad_z == 0, "R1", "nonzero data outside window", bad_z, 0);
    if (wt) chk(wait_viol == 0, "R10", "windows during wait", wait_viol, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    chk(pic_win_o == 0 && slice_win_o == 0 && mb_win_o == 0 && mb_fld_o == 0, "R1",
        "strobes after reset", {pic_win_o, slice_win_o, mb_win_o, mb_fld_o}, 0);
    chk(pic_struct_o == 2'd0, "R1", "structure after reset", pic_struct_o, 0);
    chk(first_fld_n_o == 1'b1, "R1", "first field flag after reset", first_fld_n_o, 1);
    chk(pix_o == 32'd0, "R1", "data after reset", pix_o, 0);
  endtask

  task automatic test_frame_order();
    int lo;
    load_buf(8'h11);
    run_pic(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, lo);
  endtask

  task automatic test_field_order();
    int lo;
    load_buf(8'h22);
    run_pic(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, lo);
  endtask

  task automatic test_field_pictures();
    int lo;
    load_buf(8'h33);
    run_pic(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, lo);
    run_pic(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, lo);
  endtask

  task automatic test_wait();
    int lo;
    load_buf(8'h44);
    run_pic(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, lo);
  endtask

  task automatic test_back_to_back();
    int lo;
    run_pic(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, lo);
    run_pic(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, lo);
    chk(lo > 128, "R8", "picture gap after early request", lo, 129);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_frame_order();
    test_field_order();
    test_field_pictures();
    test_wait();
    test_back_to_back();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule